// File: doc/BRIEF.md
# Serial Interrupt Prioritizer with Status Vector

This block collects the interrupt sources of one character-oriented serial channel and presents them to a host. Three sources are tracked: the transmit buffer has emptied, a received character is waiting, and a receive special condition (parity, overrun or framing error) has been latched. A single interrupt line, gated by a master enable, tells the host that service is needed. A readable vector encodes the highest-priority source that is pending right now. Software can therefore loop on the vector, service whatever it names, and clear that condition. The vector then names the next source, with no acknowledge cycle in between.

The serial shifters and the bus decoder are outside this block. Plain one-cycle strobes stand in for them. They mark a character written by software, that character moving into the transmit shift register, a character received with its error flags, and a data-register read.

Software writes through a small port selected by `wr_sel`:
- 0 is the command register.
- 1 is the vector base.
- 2 is the control register, where bit 0 is the master enable.
- 3 is unused.

Top module: `sirq_prio`

## Requirements
- R1: After reset no source is pending, `irq` is low, `err_stat_o` is 0x00, the master enable is clear and `vec_o` reads 0x07.
- R2: The transmit-empty source becomes pending only when `tx_shift_load` arrives after at least one `tx_write` since the last shift-load. A shift-load with no preceding write leaves it clear, and a write alone does not set it.
- R3: `vec_o` carries the vector base in bits [7:4], the source code in bits [3:1] and a nothing-pending flag in bit 0. The codes are 011 for special condition, 010 for receive available and 000 for transmit empty. When nothing is pending the low nibble is 0111. A base write (`wr_sel`=1) keeps only `wr_data[7:4]`.
- R4: Writing 0x28 to the command register clears the transmit-empty pending flag. No new transmit-empty interrupt follows until software writes another character and it is shift-loaded.
- R5: Priority from highest to lowest is special condition, then receive available, then transmit empty. The vector moves to the next pending source in the cycle after the higher one is cleared.
- R6: `rx_char` sets receive-available pending and `rx_read` clears it. When both arrive in the same cycle the flag stays set.
- R7: Error flags are sampled only together with `rx_char`. Parity latches into `err_stat_o` bit 4, overrun into bit 5 and framing into bit 6. Any latched bit makes the special condition pending.
- R8: Latched error bits stay set across later characters, with or without errors, until the error reset command.
- R9: Writing 0x30 to the command register clears all error status bits and with them the special condition.
- R10: `irq` is registered. It equals the master enable AND any pending source, one cycle after both are updated. Clearing and then setting the enable while a source stays pending gives a fresh rising edge.
- R11: Command codes other than 0x28 and 0x30, and any write with `wr_sel`=3, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 base, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| tx_write | input | 1 | Software wrote a transmit character |
| tx_shift_load | input | 1 | Transmit character moved into the shift register |
| rx_char | input | 1 | A character was received |
| rx_read | input | 1 | Software read the receive data register |
| rx_err_parity | input | 1 | Parity error on the character in `rx_char` |
| rx_err_overrun | input | 1 | Overrun error on the character in `rx_char` |
| rx_err_framing | input | 1 | Framing error on the character in `rx_char` |
| irq | output | 1 | Interrupt request |
| vec_o | output | 8 | Status vector |
| err_stat_o | output | 8 | Latched error status |

## Verification
Every pending flag feeds `vec_o` combinationally. A flag that is set or cleared wrongly therefore shows at the ports in the cycle right after the offending strobe, as a wrong code or a wrong bit 0. A wrong `irq` level appears one cycle later. A flag that priority hides, such as a transmit-empty pending behind a receive source, surfaces only once the higher sources are cleared. For that reason the sequences clear sources one at a time and read the vector after each step. Error latching is seen directly on `err_stat_o` in the cycle after the character arrives.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam logic [7:0] CMD_TXIP_RST = 8'h28;
  localparam logic [7:0] CMD_ERR_RST  = 8'h30;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef enum logic [2:0] {
    CODE_TX = 3'b000,
    CODE_RX = 3'b010,
    CODE_SP = 3'b011
  } code_e;

  typedef struct packed {
    logic sp;
    logic rx;
    logic tx;
  } pend_t;
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CODE_W  = 3,
  parameter int MIE_BIT = 0,
  localparam int BASE_W = DW - CODE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic              txip_clr,
  output logic              err_clr,
  output logic [BASE_W-1:0] base_q,
  output logic              mie_q
);
  logic              cmd_wr, base_wr, ctrl_wr;
  logic [BASE_W-1:0] base_d;
  logic              mie_d;

  always_comb begin
    cmd_wr   = wr_en && (wr_sel == SEL_CMD);
    base_wr  = wr_en && (wr_sel == SEL_BASE);
    ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    txip_clr = cmd_wr && (wr_data == CMD_TXIP_RST);
    err_clr  = cmd_wr && (wr_data == CMD_ERR_RST);
    base_d   = base_q;
    mie_d    = mie_q;
    if (base_wr) base_d = wr_data[DW-1 -: BASE_W];
    if (ctrl_wr) mie_d  = wr_data[MIE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mie_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      mie_q  <= mie_d;
    end
  end

  // R11: writes to the unused select never move base or enable
  p_nosel_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(base_q) && $stable(mie_q)));
endmodule

// File: rtl/sirq_src.sv
module sirq_src
  import sirq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int PAR_BIT = 4,
  parameter int OVR_BIT = 5,
  parameter int FRM_BIT = 6,
  localparam int NERR   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_write,
  input  logic          tx_shift_load,
  input  logic          rx_char,
  input  logic          rx_read,
  input  logic          err_par,
  input  logic          err_ovr,
  input  logic          err_frm,
  input  logic          txip_clr,
  input  logic          err_clr,
  output pend_t         pend,
  output logic [DW-1:0] err_stat
);
  logic            tx_armed_q, tx_armed_d;
  logic            tx_pend_q, tx_pend_d;
  logic            rx_pend_q, rx_pend_d;
  logic [NERR-1:0] err_q, err_d, err_hit;
  logic            tx_fire;

  always_comb begin
    tx_fire    = tx_shift_load && tx_armed_q;
    // a write arms; a shift-load consumes the arm unless a new write lands
    tx_armed_d = tx_write | (tx_armed_q & ~tx_shift_load);
    tx_pend_d  = tx_fire | (tx_pend_q & ~txip_clr);
    rx_pend_d  = rx_char | (rx_pend_q & ~rx_read);
    err_hit    = {NERR{rx_char}} & {err_frm, err_ovr, err_par};
    err_d      = err_hit | (err_q & ~{NERR{err_clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_armed_q <= 1'b0;
      tx_pend_q  <= 1'b0;
      rx_pend_q  <= 1'b0;
      err_q      <= '0;
    end else begin
      tx_armed_q <= tx_armed_d;
      tx_pend_q  <= tx_pend_d;
      rx_pend_q  <= rx_pend_d;
      err_q      <= err_d;
    end
  end

  always_comb begin
    err_stat          = '0;
    err_stat[PAR_BIT] = err_q[0];
    err_stat[OVR_BIT] = err_q[1];
    err_stat[FRM_BIT] = err_q[2];
    pend.sp = |err_q;
    pend.rx = rx_pend_q;
    pend.tx = tx_pend_q;
  end

  // R2: transmit-empty rises only from a shift-load
  p_tx_from_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pend_q) |-> $past(tx_shift_load));
  // R4: the reset command drops the flag when no new fire coincides
  p_txip_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txip_clr && !tx_fire) |=> !tx_pend_q);
  // R6: a received character always leaves the flag set
  p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char |=> rx_pend_q);
  // R8: latched errors hold without the reset command
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q && !err_clr) |=> (|err_q));
  // R7: error status cannot rise without a character
  p_err_needs_char_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|err_q) |-> $past(rx_char));
endmodule

// File: rtl/sirq_vec.sv
module sirq_vec
  import sirq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CODE_W  = 3,
  localparam int BASE_W = DW - CODE_W - 1
) (
  input  logic [BASE_W-1:0] base_q,
  input  pend_t             pend,
  output logic [DW-1:0]     vec,
  output logic              any_pend
);
  logic [CODE_W-1:0] code;
  logic              none;

  always_comb begin
    none = 1'b0;
    if (pend.sp)      code = CODE_SP;
    else if (pend.rx) code = CODE_RX;
    else if (pend.tx) code = CODE_TX;
    else begin
      code = CODE_SP;
      none = 1'b1;
    end
    any_pend = ~none;
    vec      = {base_q, code, none};
  end
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
  import sirq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CODE_W  = 3,
  parameter int MIE_BIT = 0,
  parameter int PAR_BIT = 4,
  parameter int OVR_BIT = 5,
  parameter int FRM_BIT = 6,
  localparam int BASE_W = DW - CODE_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          tx_write,
  input  logic          tx_shift_load,
  input  logic          rx_char,
  input  logic          rx_read,
  input  logic          rx_err_parity,
  input  logic          rx_err_overrun,
  input  logic          rx_err_framing,
  output logic          irq,
  output logic [DW-1:0] vec_o,
  output logic [DW-1:0] err_stat_o
);
  logic              rst_meta_q, rst_sync_n;
  logic              txip_clr, err_clr, mie_q, any_pend;
  logic [BASE_W-1:0] base_q;
  pend_t             pend;
  logic              irq_d, irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sirq_regs #(.DW(DW), .CODE_W(CODE_W), .MIE_BIT(MIE_BIT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .txip_clr(txip_clr), .err_clr(err_clr),
    .base_q(base_q), .mie_q(mie_q)
  );

  sirq_src #(.DW(DW), .PAR_BIT(PAR_BIT), .OVR_BIT(OVR_BIT), .FRM_BIT(FRM_BIT)) u_src (
    .clk(clk), .rst_n(rst_sync_n), .tx_write(tx_write),
    .tx_shift_load(tx_shift_load), .rx_char(rx_char), .rx_read(rx_read),
    .err_par(rx_err_parity), .err_ovr(rx_err_overrun), .err_frm(rx_err_framing),
    .txip_clr(txip_clr), .err_clr(err_clr), .pend(pend), .err_stat(err_stat_o)
  );

  sirq_vec #(.DW(DW), .CODE_W(CODE_W)) u_vec (
    .base_q(base_q), .pend(pend), .vec(vec_o), .any_pend(any_pend)
  );

  always_comb irq_d = mie_q & any_pend;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R10: interrupt drops one cycle after the enable is clear
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mie_q |=> !irq_q);
  // R10: a rising request needs enable and a pending source the cycle before
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_q) |-> ($past(mie_q) && !$past(vec_o[0])));
  // R9: error reset leaves no special code in the vector
  p_errrst_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_clr && !rx_char) |=> (err_stat_o == '0));
endmodule

// File: tb/sim_sirq_prio.sv
module sim_sirq_prio;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       tx_write = 1'b0, tx_shift_load = 1'b0, rx_char = 1'b0, rx_read = 1'b0;
  logic       e_par = 1'b0, e_ovr = 1'b0, e_frm = 1'b0;
  logic       irq;
  logic [7:0] vec_o, err_stat_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] vec;
    logic       irq;
    logic [7:0] err;
    string      tag;
  } exp_t;
  exp_t q[$];
  event chk;

  always #2 clk = ~clk;

  sirq_prio u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tx_write(tx_write), .tx_shift_load(tx_shift_load), .rx_char(rx_char),
    .rx_read(rx_read), .rx_err_parity(e_par), .rx_err_overrun(e_ovr),
    .rx_err_framing(e_frm), .irq(irq), .vec_o(vec_o), .err_stat_o(err_stat_o)
  );

  // strobe bits: 0 tx_write, 1 tx_shift_load, 2 rx_char, 3 rx_read,
  // 4 parity, 5 overrun, 6 framing
  task automatic act(input logic [6:0] s, input logic we, input logic [1:0] sel,
                     input logic [7:0] d);
    @(negedge clk);
    {e_frm, e_ovr, e_par, rx_read, rx_char, tx_shift_load, tx_write} = s;
    wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    {e_frm, e_ovr, e_par, rx_read, rx_char, tx_shift_load, tx_write} = '0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'h00;
    @(negedge clk);
  endtask

  task automatic expect_now(input logic [7:0] v, input logic i, input logic [7:0] e,
                            input string tag);
    exp_t x;
    x.vec = v; x.irq = i; x.err = e; x.tag = tag;
    q.push_back(x);
    ->chk;
  endtask

  initial begin
    forever begin
      @(chk);
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        total++;
        if (vec_o !== x.vec || irq !== x.irq || err_stat_o !== x.err) begin
          bad++;
          $display("FAIL %s: vec=%h irq=%b err=%h expected vec=%h irq=%b err=%h",
                   x.tag, vec_o, irq, err_stat_o, x.vec, x.irq, x.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(8'h07, 0, 8'h00, "R1 reset state");
    act(7'h02, 0, 2'd0, 8'h00);
    expect_now(8'h07, 0, 8'h00, "R2 shift-load with no write");
    act(7'h00, 1, 2'd1, 8'hAF);
    expect_now(8'hA7, 0, 8'h00, "R3 base keeps upper nibble");
    act(7'h00, 1, 2'd2, 8'h01);
    expect_now(8'hA7, 0, 8'h00, "R10 enable with nothing pending");
    act(7'h01, 0, 2'd0, 8'h00);
    expect_now(8'hA7, 0, 8'h00, "R2 write alone");
    act(7'h02, 0, 2'd0, 8'h00);
    expect_now(8'hA0, 1, 8'h00, "R2 write then shift-load");
    act(7'h00, 1, 2'd0, 8'h18);
    expect_now(8'hA0, 1, 8'h00, "R11 unknown command");
    act(7'h00, 1, 2'd3, 8'h28);
    expect_now(8'hA0, 1, 8'h00, "R11 unused select");
    act(7'h00, 1, 2'd0, 8'h28);
    expect_now(8'hA7, 0, 8'h00, "R4 tx reset command");
    act(7'h02, 0, 2'd0, 8'h00);
    expect_now(8'hA7, 0, 8'h00, "R4 no rearm without write");
    act(7'h04, 0, 2'd0, 8'h00);
    expect_now(8'hA4, 1, 8'h00, "R6 receive sets");
    act(7'h01, 0, 2'd0, 8'h00);
    act(7'h02, 0, 2'd0, 8'h00);
    expect_now(8'hA4, 1, 8'h00, "R5 rx above tx");
    act(7'h08, 0, 2'd0, 8'h00);
    expect_now(8'hA0, 1, 8'h00, "R5 advance to tx");
    act(7'h14, 0, 2'd0, 8'h00);
    expect_now(8'hA6, 1, 8'h10, "R7 parity latch");
    act(7'h64, 0, 2'd0, 8'h00);
    expect_now(8'hA6, 1, 8'h70, "R8 overrun framing accumulate");
    act(7'h04, 0, 2'd0, 8'h00);
    expect_now(8'hA6, 1, 8'h70, "R8 clean char keeps errors");
    act(7'h00, 1, 2'd0, 8'h30);
    expect_now(8'hA4, 1, 8'h00, "R9 error reset");
    act(7'h0C, 0, 2'd0, 8'h00);
    expect_now(8'hA4, 1, 8'h00, "R6 read and char together");
    act(7'h08, 0, 2'd0, 8'h00);
    expect_now(8'hA0, 1, 8'h00, "R5 read clears rx");
    act(7'h00, 1, 2'd2, 8'h00);
    expect_now(8'hA0, 0, 8'h00, "R10 enable cleared");
    act(7'h00, 1, 2'd2, 8'h01);
    expect_now(8'hA0, 1, 8'h00, "R10 fresh edge");
    act(7'h00, 1, 2'd0, 8'h28);
    expect_now(8'hA7, 0, 8'h00, "R4 tx reset again");
    act(7'h70, 0, 2'd0, 8'h00);
    expect_now(8'hA7, 0, 8'h00, "R7 error flags without char");
    @(negedge clk);
    wait (q.size() == 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule